// File: doc/BRIEF.md
# Effective Address Generator with Auto-Indexing Pointers

This block turns the addressing fields of a memory-reference instruction into a final 15-bit effective address. The fields are an indirect flag, a 2-bit index mode and an 8-bit displacement. The base for the address is zero (page zero), the program counter, or one of two base accumulators. The execution unit pulses `start` with those fields and waits for `done`. At that point `ea` holds the resolved address, and it stays stable until the next resolution completes.

When the indirect flag is set, the block walks a pointer chain through a single-port synchronous memory. A read issued in one cycle returns its data in the next cycle. In each fetched word, the most significant bit (bit 15) is the "follow again" flag and bits 14:0 carry an address. The chain has no length limit.

Pointer words read from a small window of low memory are adjusted as they pass through the chain, and the adjusted word is written back. Words in locations 0x10 to 0x17 are incremented, and words in 0x18 to 0x1F are decremented. The adjusted word is also the one used for the next step of the chain.

Top module: `ea_gen`

## Requirements
- R1: Index mode 2'b00 yields the displacement zero-extended to 15 bits (page-zero address 0x000 to 0x0FF), with no sign extension.
- R2: Index mode 2'b01 yields pc plus the sign-extended displacement (-128 to +127), modulo 2^15.
- R3: Index mode 2'b10 adds the sign-extended displacement to `acc2`, and mode 2'b11 adds it to `acc3`, both modulo 2^15.
- R4: When `indirect`=0, `done` pulses in the cycle after the edge that accepts `start`. In that case `ea` equals the computed address, `busy` stays low and no memory access is made.
- R5: When `indirect`=1, the word at the computed address is read. If its bit 15 is 1, bits 14:0 are the next address to read. If bit 15 is 0, bits 14:0 are the effective address. Any number of levels is followed.
- R6: A word read from locations 0x10 to 0x17 has its bits 14:0 incremented modulo 2^15, with bit 15 unchanged. The adjusted word is written back to the same location in the cycle after the read data returns, and it is used for the next step.
- R7: A word read from locations 0x18 to 0x1F is decremented in the same way: bits 14:0 modulo 2^15, bit 15 kept, written back, and used for the next step. Locations 0x0F and 0x20 are not adjusted.
- R8: Each indirect level costs one read cycle plus one data cycle, and one write cycle for a window location. `done` arrives 1 + 2·levels + writes edges after `start` is accepted. `busy` is high from the accepting edge until `done`, and it is low while `done` is high.
- R9: `start` is ignored while `busy` is high. `ea` changes only in a cycle where `done` is high.
- R10: `mem_rd` and `mem_we` are never high together. Every write goes to the address read two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a resolution (accepted when not busy) |
| indirect | input | 1 | Indirect flag of the instruction |
| mode | input | 2 | Index mode: 0 page zero, 1 pc, 2 acc2, 3 acc3 |
| disp | input | 8 | Displacement field |
| pc | input | 15 | Program counter |
| acc2 | input | 15 | Address bits of the first base accumulator |
| acc3 | input | 15 | Address bits of the second base accumulator |
| mem_rd | output | 1 | Memory read request, data returned next cycle |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 16 | Write-back data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle completion strobe |
| ea | output | 15 | Effective address, held until the next `done` |

## Verification
The bench goes after the window boundaries at 0x0F, 0x17, 0x18 and 0x20. A design with an off-by-one decode would adjust the wrong word or skip the write-back, and the bench sees this in both the latency and the memory contents. It also checks that the increment wraps from 0x7FFF to 0 and the decrement wraps from 0 to 0x7FFF with the flag bit preserved. A design that carried into bit 15 would end the chain early or follow it into the wrong place. Further checks cover a negative pc displacement, an unsigned page-zero displacement of 0xFF, and a three-level chain. Finally, a `start` pulse arriving mid-chain must not disturb the result or produce a second `done`.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_DATA = 2'd2,
    ST_WR   = 2'd3
  } ea_state_e;

  localparam logic [1:0] MODE_PAGE0 = 2'd0;
  localparam logic [1:0] MODE_PC    = 2'd1;
  localparam logic [1:0] MODE_ACC2  = 2'd2;
  localparam logic [1:0] MODE_ACC3  = 2'd3;
endpackage

// File: rtl/ea_base_calc.sv
module ea_base_calc
  import ea_pkg::*;
#(
  parameter int AW     = 15,
  parameter int DISP_W = 8
) (
  input  logic [1:0]        mode,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     acc2,
  input  logic [AW-1:0]     acc3,
  output logic [AW-1:0]     addr
);
  localparam int EXT_W = AW - DISP_W;

  logic [AW-1:0] disp_sx;
  logic [AW-1:0] disp_zx;
  logic [AW-1:0] base;

  assign disp_sx = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign disp_zx = {{EXT_W{1'b0}}, disp};

  always_comb begin
    unique case (mode)
      MODE_PC:   base = pc;
      MODE_ACC2: base = acc2;
      MODE_ACC3: base = acc3;
      default:   base = '0;
    endcase
  end

  always_comb begin
    if (mode == MODE_PAGE0) addr = disp_zx;
    else                    addr = base + disp_sx;
  end
endmodule

// File: rtl/ea_autoindex.sv
module ea_autoindex #(
  parameter int AW           = 15,
  parameter int DW           = 16,
  parameter int unsigned WIN_BASE = 16,
  parameter int unsigned WIN_SPAN = 8
) (
  input  logic [AW-1:0] loc,
  input  logic [DW-1:0] word_in,
  output logic          is_auto,
  output logic [DW-1:0] word_out
);
  localparam logic [AW-1:0] INC_LO = AW'(WIN_BASE);
  localparam logic [AW-1:0] INC_HI = AW'(WIN_BASE + WIN_SPAN - 1);
  localparam logic [AW-1:0] DEC_LO = AW'(WIN_BASE + WIN_SPAN);
  localparam logic [AW-1:0] DEC_HI = AW'(WIN_BASE + 2 * WIN_SPAN - 1);
  localparam logic [AW-1:0] ONE    = AW'(1);

  logic          in_inc;
  logic          in_dec;
  logic [AW-1:0] field;

  assign in_inc  = (loc >= INC_LO) && (loc <= INC_HI);
  assign in_dec  = (loc >= DEC_LO) && (loc <= DEC_HI);
  assign is_auto = in_inc || in_dec;

  always_comb begin
    if (in_inc)      field = word_in[AW-1:0] + ONE;
    else if (in_dec) field = word_in[AW-1:0] - ONE;
    else             field = word_in[AW-1:0];
    word_out = {word_in[DW-1], field};
  end
endmodule

// File: rtl/ea_chain_fsm.sv
module ea_chain_fsm
  import ea_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          indirect,
  input  logic [AW-1:0] first_addr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          is_auto,
  input  logic [DW-1:0] adj_word,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea
);
  ea_state_e     state_q, state_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [DW-1:0] word_q, word_d;
  logic [AW-1:0] ea_q, ea_d;
  logic          done_q, done_d;
  logic          cur_en, word_en, ea_en;
  logic [DW-1:0] eval_word;

  assign eval_word = (state_q == ST_WR) ? word_q : mem_rdata;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    word_d  = word_q;
    ea_d    = ea_q;
    done_d  = 1'b0;
    cur_en  = 1'b0;
    word_en = 1'b0;
    ea_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (indirect) begin
            cur_d   = first_addr;
            cur_en  = 1'b1;
            state_d = ST_RD;
          end else begin
            ea_d   = first_addr;
            ea_en  = 1'b1;
            done_d = 1'b1;
          end
        end
      end
      ST_RD: state_d = ST_DATA;
      ST_DATA, ST_WR: begin
        if ((state_q == ST_DATA) && is_auto) begin
          word_d  = adj_word;
          word_en = 1'b1;
          state_d = ST_WR;
        end else if (eval_word[DW-1]) begin
          cur_d   = eval_word[AW-1:0];
          cur_en  = 1'b1;
          state_d = ST_RD;
        end else begin
          ea_d    = eval_word[AW-1:0];
          ea_en   = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      cur_q   <= '0;
      word_q  <= '0;
      ea_q    <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cur_en)  cur_q  <= cur_d;
      if (word_en) word_q <= word_d;
      if (ea_en)   ea_q   <= ea_d;
    end
  end

  assign mem_rd    = (state_q == ST_RD);
  assign mem_we    = (state_q == ST_WR);
  assign mem_addr  = cur_q;
  assign mem_wdata = word_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign ea        = ea_q;

  // R4: direct resolution completes in one edge without becoming busy
  p_direct_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !indirect) |=> (done && !busy && !mem_rd));

  // R5: indirect resolution first reads the computed address
  p_first_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && indirect) |=> (busy && mem_rd && mem_addr == $past(first_addr)));

  // R7: write-back keeps the follow flag of the word just read
  p_flag_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata[DW-1] == $past(mem_rdata[DW-1])));

  // R8: done is never seen together with busy
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9: ea only moves alongside a done strobe
  p_ea_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ea));

  // R10: read and write are exclusive
  p_rw_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_we));

  // R10: a write targets the location read two cycles earlier
  p_wb_same_loc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2)));
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW     = 15,
  parameter int DISP_W = 8,
  parameter int unsigned WIN_BASE = 16,
  parameter int unsigned WIN_SPAN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              indirect,
  input  logic [1:0]        mode,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     pc,
  input  logic [AW-1:0]     acc2,
  input  logic [AW-1:0]     acc3,
  output logic              mem_rd,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [AW:0]       mem_wdata,
  input  logic [AW:0]       mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     ea
);
  localparam int DW = AW + 1;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [AW-1:0] first_addr;
  logic          is_auto;
  logic [DW-1:0] adj_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ea_base_calc #(.AW(AW), .DISP_W(DISP_W)) u_base (
    .mode (mode),
    .disp (disp),
    .pc   (pc),
    .acc2 (acc2),
    .acc3 (acc3),
    .addr (first_addr)
  );

  ea_autoindex #(.AW(AW), .DW(DW), .WIN_BASE(WIN_BASE), .WIN_SPAN(WIN_SPAN)) u_auto (
    .loc      (mem_addr),
    .word_in  (mem_rdata),
    .is_auto  (is_auto),
    .word_out (adj_word)
  );

  ea_chain_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .indirect   (indirect),
    .first_addr (first_addr),
    .mem_rdata  (mem_rdata),
    .is_auto    (is_auto),
    .adj_word   (adj_word),
    .mem_rd     (mem_rd),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .busy       (busy),
    .done       (done),
    .ea         (ea)
  );
endmodule

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        indirect = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [7:0]  disp = 8'd0;
  logic [14:0] pc = 15'd0;
  logic [14:0] acc2 = 15'h0123;
  logic [14:0] acc3 = 15'h0200;
  logic        mem_rd, mem_we, busy, done;
  logic [14:0] mem_addr, ea;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'd0;
  logic [15:0] mem [1024];

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .indirect(indirect), .mode(mode),
    .disp(disp), .pc(pc), .acc2(acc2), .acc3(acc3), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .ea(ea)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic run_ea(input logic ind, input logic [1:0] md, input logic [7:0] dp,
                        input logic [14:0] p, input logic [14:0] exp_ea, input int exp_lat,
                        input int exp_rd, input int exp_wr, input string req);
    int n = 0;
    int nrd = 0;
    int nwr = 0;
    @(negedge clk);
    indirect = ind; mode = md; disp = dp; pc = p; start = 1'b1;
    do begin
      @(negedge clk);
      start = 1'b0;
      n++;
      if (mem_rd) nrd++;
      if (mem_we) nwr++;
    end while (!done && n < 40);
    chk({req, " ea"}, 32'(ea), 32'(exp_ea));
    chk({req, " latency R8"}, 32'(n), 32'(exp_lat));
    chk({req, " reads R10"}, 32'(nrd), 32'(exp_rd));
    chk({req, " writes R10"}, 32'(nwr), 32'(exp_wr));
    chk({req, " busy low at done R8"}, 32'(busy), 32'd0);
  endtask

  // fields: ind, mode, disp, pc, exp_ea, latency, reads, writes
  localparam int NV = 11;
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'hFF, 15'h0000, 15'h00FF, 4'd1, 4'd0, 4'd0},  // R1
    {1'b0, 2'd1, 8'h20, 15'h7FF0, 15'h0010, 4'd1, 4'd0, 4'd0},  // R2 wrap
    {1'b0, 2'd1, 8'h80, 15'h0005, 15'h7F85, 4'd1, 4'd0, 4'd0},  // R2 negative
    {1'b0, 2'd2, 8'h7F, 15'h0000, 15'h01A2, 4'd1, 4'd0, 4'd0},  // R3 acc2
    {1'b0, 2'd3, 8'hFE, 15'h0000, 15'h01FE, 4'd1, 4'd0, 4'd0},  // R3 acc3
    {1'b1, 2'd0, 8'h50, 15'h0000, 15'h0077, 4'd3, 4'd1, 4'd0},  // R5 one level
    {1'b1, 2'd0, 8'h60, 15'h0000, 15'h0155, 4'd7, 4'd3, 4'd0},  // R5 three levels
    {1'b1, 2'd1, 8'hF0, 15'h0100, 15'h0222, 4'd3, 4'd1, 4'd0},  // R2 R5
    {1'b1, 2'd0, 8'h0F, 15'h0000, 15'h0123, 4'd3, 4'd1, 4'd0},  // R7 below window
    {1'b1, 2'd0, 8'h20, 15'h0000, 15'h0124, 4'd3, 4'd1, 4'd0},  // R7 above window
    {1'b1, 2'd3, 8'h10, 15'h0000, 15'h0033, 4'd3, 4'd1, 4'd0}   // R3 R5
  };

  function automatic string vec_req(input int i);
    case (i)
      0: return "R1";
      1, 2: return "R2";
      3, 4: return "R3";
      5, 6: return "R5";
      7: return "R2/R5";
      8, 9: return "R7";
      default: return "R3/R5";
    endcase
  endfunction

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    mem[10'h050] = 16'h0077;
    mem[10'h060] = 16'h8070;
    mem[10'h070] = 16'h8080;
    mem[10'h080] = 16'h0155;
    mem[10'h0F0] = 16'h0222;
    mem[10'h00F] = 16'h0123;
    mem[10'h020] = 16'h0124;
    mem[10'h210] = 16'h0033;
    mem[10'h010] = 16'h0300;
    mem[10'h018] = 16'h0000;
    mem[10'h01F] = 16'h8201;
    mem[10'h200] = 16'h0044;
    mem[10'h017] = 16'hFFFF;
    mem[10'h000] = 16'h0009;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("reset busy R8", 32'(busy), 32'd0);
    chk("reset done R8", 32'(done), 32'd0);
    chk("reset mem_rd R10", 32'(mem_rd), 32'd0);
    chk("reset mem_we R10", 32'(mem_we), 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_ea(VEC[i][52], VEC[i][51:50], VEC[i][49:42], VEC[i][41:27], VEC[i][26:12],
             int'(VEC[i][11:8]), int'(VEC[i][7:4]), int'(VEC[i][3:0]), vec_req(i));
    end
    chk("R7 0x0F untouched", 32'(mem[10'h00F]), 32'h0123);
    chk("R7 0x20 untouched", 32'(mem[10'h020]), 32'h0124);

    // R6 auto-increment, twice
    run_ea(1'b1, 2'd0, 8'h10, 15'h0, 15'h0301, 4, 1, 1, "R6 inc first");
    run_ea(1'b1, 2'd0, 8'h10, 15'h0, 15'h0302, 4, 1, 1, "R6 inc second");
    chk("R6 written back", 32'(mem[10'h010]), 32'h0302);
    // R6 top of window, wrap with flag kept, then follow
    run_ea(1'b1, 2'd0, 8'h17, 15'h0, 15'h0009, 6, 2, 1, "R6 wrap follow");
    chk("R6 wrap written", 32'(mem[10'h017]), 32'h8000);
    // R7 decrement wrap below zero
    run_ea(1'b1, 2'd0, 8'h18, 15'h0, 15'h7FFF, 4, 1, 1, "R7 dec wrap");
    chk("R7 dec written", 32'(mem[10'h018]), 32'h7FFF);
    // R7 top of window with follow flag
    run_ea(1'b1, 2'd0, 8'h1F, 15'h0, 15'h0044, 6, 2, 1, "R7 dec follow");
    chk("R7 dec follow written", 32'(mem[10'h01F]), 32'h8200);

    // R9: start while busy is ignored, ea held after done
    begin
      int n = 0;
      int ndone = 0;
      @(negedge clk);
      indirect = 1'b1; mode = 2'd0; disp = 8'h60; start = 1'b1;
      @(negedge clk); n++; start = 1'b0;
      @(negedge clk); n++;
      indirect = 1'b0; disp = 8'h33; start = 1'b1;
      @(negedge clk); n++; start = 1'b0;
      while (!done && n < 40) begin @(negedge clk); n++; end
      chk("R9 ea unaffected by start while busy", 32'(ea), 32'h0155);
      chk("R9 latency unaffected", 32'(n), 32'd7);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (done) ndone++;
      end
      chk("R9 no extra done", 32'(ndone), 32'd0);
      chk("R9 ea held", 32'(ea), 32'h0155);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule